// File: doc/BRIEF.md
# Short-Vector Register Index Sequencer

This block turns one short-vector floating-point request into a stream of register index triples (destination, first source, second source), one triple per clock. The caller supplies the precision, the encoded register fields for the three operands, and the element count and step taken from a control register. The block checks the combination, then walks the indices through the register file's banks. Execution units, the register file itself and memory are handled elsewhere.

The register file is split into banks of eight single-precision or four double-precision registers. Each index steps by the stride and wraps around inside its own bank. A bank counts as scalar when it is the first single bank (S0 to S7) or the first or fifth double bank (D0 to D3, D16 to D19). A scalar destination turns the request into one element. A scalar second source stays fixed while the other two indices move.

Top module: `svseq_top`

## Requirements
- R1: Register indices are 5 bits. In double precision (isDouble=1) the index is base + 16*ext. In single precision it is base*2 + ext. The first triple shows these decoded values in the cycle after the accepted start.
- R2: After each element, the destination index and the first source index move to bankStart + ((pos + stride) mod bank). The bank holds 8 entries in single precision and 4 in double precision, and pos is the index's position inside its bank, so an index never leaves its bank.
- R3: The length is lenField+1, which gives 1 to 8. The stride is 1 when strideSel=0 and 2 when strideSel=1. If length*stride exceeds the bank size, unpred pulses for one cycle, starting the cycle after start, and no valid and no done follow.
- R4: A length of 1 with a stride of 2 is reported through unpred in the same way as R3.
- R5: If strideOk=0, the stride is missing and the request is reported through unpred in the same way as R3, whatever the other fields hold.
- R6: If the destination lies in a scalar bank (single index below 8; double index mod 16 below 4), exactly one triple is issued, whatever the length.
- R7: A second source in a scalar bank keeps its index for every element. Any other second source advances as in R2.
- R8: A legal request gives idxValid high on exactly the effective number of consecutive cycles, starting the cycle after start. seqDone is high for one cycle, the cycle after the last element.
- R9: startReq is ignored from the first element until the cycle in which seqDone is high, and the triple stream is not changed by it.
- R10: While reset (rstN=0) is applied and right after it, idxValid, seqDone and unpred are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to start a sequence; taken only when idle |
| isDouble | input | 1 | 1 = double precision, 0 = single precision |
| dBase | input | 4 | Destination base field |
| dExt | input | 1 | Destination extra bit |
| nBase | input | 4 | First source base field |
| nExt | input | 1 | First source extra bit |
| mBase | input | 4 | Second source base field |
| mExt | input | 1 | Second source extra bit |
| lenField | input | 3 | Length minus one |
| strideOk | input | 1 | 1 = stride setting present |
| strideSel | input | 1 | 0 = stride 1, 1 = stride 2 |
| idxValid | output | 1 | A triple is presented this cycle |
| dIdx | output | 5 | Destination index |
| nIdx | output | 5 | First source index |
| mIdx | output | 5 | Second source index |
| seqDone | output | 1 | Pulse one cycle after the last element |
| unpred | output | 1 | Pulse when the request is illegal |

## Verification
The assertions assume that the operand and control fields are stable only in the cycle in which startReq is taken, and that they may change freely at any other time. They also assume that the stride is never zero, so every step moves an index. The stimulus changes inputs only on the falling clock edge. During each run it holds startReq high with unrelated fields, which exercises the ignore rule. It then drops startReq in the done cycle, so the next request always begins from idle.

// File: rtl/svseq_pkg.sv
package svseq_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } seqCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2,
    ST_BAD  = 2'd3
  } seqState_t;
endpackage

// File: rtl/svseq_dp.sv
module svseq_dp
  import svseq_pkg::*;
#(
  parameter int BASE_W = 4,
  parameter int LEN_W = 3,
  parameter int SGL_LOG = 3,
  localparam int IDX_W = BASE_W + 1
) (
  input  logic clk,
  input  logic rstN,
  input  seqCtl_t ctl,
  input  logic isDouble,
  input  logic [BASE_W-1:0] dBase,
  input  logic dExt,
  input  logic [BASE_W-1:0] nBase,
  input  logic nExt,
  input  logic [BASE_W-1:0] mBase,
  input  logic mExt,
  input  logic [LEN_W-1:0] lenField,
  input  logic strideOk,
  input  logic strideSel,
  output logic illegal,
  output logic [LEN_W-1:0] effLenM1,
  output logic [IDX_W-1:0] dIdx,
  output logic [IDX_W-1:0] nIdx,
  output logic [IDX_W-1:0] mIdx
);
  localparam int DBL_LOG = SGL_LOG - 1;
  localparam int SGL_BANK = 1 << SGL_LOG;
  localparam int DBL_BANK = 1 << DBL_LOG;
  localparam int PW = LEN_W + 3;
  localparam logic [IDX_W-1:0] SGL_MASK = IDX_W'(SGL_BANK - 1);
  localparam logic [IDX_W-1:0] DBL_MASK = IDX_W'(DBL_BANK - 1);

  function automatic logic [IDX_W-1:0] decodeIdx(input logic dbl,
      input logic [BASE_W-1:0] base, input logic ext);
    return dbl ? {ext, base} : {base, ext};
  endfunction

  function automatic logic inScalarBank(input logic dbl, input logic [IDX_W-1:0] idx);
    if (dbl) return idx[IDX_W-2:DBL_LOG] == '0;
    return idx[IDX_W-1:SGL_LOG] == '0;
  endfunction

  function automatic logic [IDX_W-1:0] bankInc(input logic dbl,
      input logic [IDX_W-1:0] idx, input logic twoStep);
    logic [IDX_W-1:0] mask;
    logic [IDX_W-1:0] sum;
    mask = dbl ? DBL_MASK : SGL_MASK;
    sum = idx + (twoStep ? IDX_W'(2) : IDX_W'(1));
    return (idx & ~mask) | (sum & mask);
  endfunction

  logic [IDX_W-1:0] dIn, nIn, mIn;
  logic [PW-1:0] lenX, strX, prod, bankLim;
  logic dblQ, strideQ, mScalarQ;

  always_comb begin
    dIn = decodeIdx(isDouble, dBase, dExt);
    nIn = decodeIdx(isDouble, nBase, nExt);
    mIn = decodeIdx(isDouble, mBase, mExt);
    lenX = PW'(lenField) + PW'(1);
    strX = strideSel ? PW'(2) : PW'(1);
    prod = lenX * strX;
    bankLim = isDouble ? PW'(DBL_BANK) : PW'(SGL_BANK);
    illegal = !strideOk || (prod > bankLim) || ((lenField == '0) && strideSel);
    effLenM1 = inScalarBank(isDouble, dIn) ? '0 : lenField;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dIdx <= '0;
      nIdx <= '0;
      mIdx <= '0;
      dblQ <= 1'b0;
      strideQ <= 1'b0;
      mScalarQ <= 1'b0;
    end else if (ctl.load) begin
      dIdx <= dIn;
      nIdx <= nIn;
      mIdx <= mIn;
      dblQ <= isDouble;
      strideQ <= strideSel;
      mScalarQ <= inScalarBank(isDouble, mIn);
    end else if (ctl.step) begin
      dIdx <= bankInc(dblQ, dIdx, strideQ);
      nIdx <= bankInc(dblQ, nIdx, strideQ);
      if (!mScalarQ) mIdx <= bankInc(dblQ, mIdx, strideQ);
    end
  end

  // R7: a scalar-bank second source holds across a step
  a_r7_m_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && mScalarQ) |=> $stable(mIdx));
  // R2: every step moves the destination
  a_r2_d_moves: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> (dIdx != $past(dIdx)));
  // R2: a double-precision step stays inside its bank
  a_r2_same_bank: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && dblQ) |=> $stable(nIdx[IDX_W-1:DBL_LOG]));
endmodule

// File: rtl/svseq_ctrl.sv
module svseq_ctrl
  import svseq_pkg::*;
#(
  parameter int LEN_W = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic startReq,
  input  logic illegal,
  input  logic [LEN_W-1:0] effLenM1,
  output seqCtl_t ctl,
  output logic idxValid,
  output logic seqDone,
  output logic unpred
);
  seqState_t state;
  logic [LEN_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      remain <= '0;
    end else begin
      case (state)
        ST_IDLE: if (startReq) begin
          if (illegal) state <= ST_BAD;
          else begin
            state <= ST_RUN;
            remain <= effLenM1;
          end
        end
        ST_RUN: if (remain == '0) state <= ST_FIN;
                else remain <= remain - 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.load = (state == ST_IDLE) && startReq;
    ctl.step = (state == ST_RUN) && (remain != '0);
    idxValid = state == ST_RUN;
    seqDone = state == ST_FIN;
    unpred = state == ST_BAD;
  end

  // R8: done only directly after an element
  a_r8_done_after_valid: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |-> $past(idxValid));
  // R8: a stream begins only after an accepted start
  a_r8_valid_from_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idxValid) |-> $past(startReq));
  // R3: an unpredictable report brings no elements
  a_r3_bad_no_valid: assert property (@(posedge clk) disable iff (!rstN)
    unpred |=> !idxValid);
  // R9: start during a run does not break the stream
  a_r9_run_ignores_start: assert property (@(posedge clk) disable iff (!rstN)
    (idxValid && startReq) |=> (idxValid || seqDone));
endmodule

// File: rtl/svseq_top.sv
module svseq_top
  import svseq_pkg::*;
#(
  parameter int BASE_W = 4,
  parameter int LEN_W = 3,
  parameter int SGL_LOG = 3,
  localparam int IDX_W = BASE_W + 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic startReq,
  input  logic isDouble,
  input  logic [BASE_W-1:0] dBase,
  input  logic dExt,
  input  logic [BASE_W-1:0] nBase,
  input  logic nExt,
  input  logic [BASE_W-1:0] mBase,
  input  logic mExt,
  input  logic [LEN_W-1:0] lenField,
  input  logic strideOk,
  input  logic strideSel,
  output logic idxValid,
  output logic [IDX_W-1:0] dIdx,
  output logic [IDX_W-1:0] nIdx,
  output logic [IDX_W-1:0] mIdx,
  output logic seqDone,
  output logic unpred
);
  seqCtl_t ctl;
  logic illegal;
  logic [LEN_W-1:0] effLenM1;

  svseq_ctrl #(.LEN_W(LEN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .illegal(illegal),
    .effLenM1(effLenM1), .ctl(ctl), .idxValid(idxValid),
    .seqDone(seqDone), .unpred(unpred)
  );

  svseq_dp #(.BASE_W(BASE_W), .LEN_W(LEN_W), .SGL_LOG(SGL_LOG)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .isDouble(isDouble),
    .dBase(dBase), .dExt(dExt), .nBase(nBase), .nExt(nExt),
    .mBase(mBase), .mExt(mExt), .lenField(lenField),
    .strideOk(strideOk), .strideSel(strideSel), .illegal(illegal),
    .effLenM1(effLenM1), .dIdx(dIdx), .nIdx(nIdx), .mIdx(mIdx)
  );
endmodule

// File: tb/svseq_top_test.sv
module svseq_top_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0, isDouble = 1'b0;
  logic [3:0] dBase = '0, nBase = '0, mBase = '0;
  logic dExt = 1'b0, nExt = 1'b0, mExt = 1'b0;
  logic [2:0] lenField = '0;
  logic strideOk = 1'b0, strideSel = 1'b0;
  logic idxValid, seqDone, unpred;
  logic [4:0] dIdx, nIdx, mIdx;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  svseq_top uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .isDouble(isDouble),
    .dBase(dBase), .dExt(dExt), .nBase(nBase), .nExt(nExt),
    .mBase(mBase), .mExt(mExt), .lenField(lenField),
    .strideOk(strideOk), .strideSel(strideSel), .idxValid(idxValid),
    .dIdx(dIdx), .nIdx(nIdx), .mIdx(mIdx), .seqDone(seqDone), .unpred(unpred)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int decIdx(input int dbl, input int base, input int ext);
    return dbl ? base + 16 * ext : base * 2 + ext;
  endfunction

  function automatic int isScalar(input int dbl, input int idx);
    return dbl ? ((idx % 16) < 4) : (idx < 8);
  endfunction

  function automatic int stepIdx(input int dbl, input int idx, input int st);
    int bank;
    bank = dbl ? 4 : 8;
    return (idx / bank) * bank + ((idx % bank) + st) % bank;
  endfunction

  task automatic junkStart(input int k);
    startReq = 1'b1;
    dBase = 4'(k * 3 + 9);
    nBase = 4'(k + 5);
    mBase = 4'(k * 7);
    lenField = 3'(k);
    strideOk = 1'(k);
  endtask

  task automatic runCase(input int dbl, input int lf, input int ok, input int ss, input int rs);
    int len, st, bank, bad, elen, ed, en, em;
    int db, de, nb, ne, mb, me;
    len = lf + 1;
    st = ss ? 2 : 1;
    bank = dbl ? 4 : 8;
    db = (rs * 5 + 3) % 16; de = rs % 2;
    nb = (rs * 7 + 1) % 16; ne = (rs / 2) % 2;
    mb = (rs * 3 + 2) % 16; me = (rs / 4) % 2;
    bad = (!ok) || (len * st > bank) || (len == 1 && st != 1);
    ed = decIdx(dbl, db, de);
    en = decIdx(dbl, nb, ne);
    em = decIdx(dbl, mb, me);
    elen = isScalar(dbl, ed) ? 1 : len;
    @(negedge clk);
    isDouble = 1'(dbl); lenField = 3'(lf); strideOk = 1'(ok); strideSel = 1'(ss);
    dBase = 4'(db); dExt = 1'(de); nBase = 4'(nb); nExt = 1'(ne);
    mBase = 4'(mb); mExt = 1'(me);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    if (bad) begin
      chk(ok ? ((lf == 0) ? "R4 unpred" : "R3 unpred") : "R5 unpred", unpred, 1);
      chk("R3 no valid when unpred", idxValid, 0);
      @(negedge clk);
      chk("R3 no done after unpred", seqDone, 0);
      chk("R3 no valid after unpred", idxValid, 0);
    end else begin
      for (int i = 0; i < elen; i++) begin
        chk("R8 valid", idxValid, 1);
        chk(i == 0 ? "R1 dest" : "R2 dest", dIdx, ed);
        chk(i == 0 ? "R1 src1" : "R2 src1", nIdx, en);
        chk(isScalar(dbl, em) ? "R7 src2 frozen" : "R7 src2", mIdx, em);
        chk("R3 unpred low", unpred, 0);
        ed = stepIdx(dbl, ed, st);
        en = stepIdx(dbl, en, st);
        if (!isScalar(dbl, em)) em = stepIdx(dbl, em, st);
        if (i < elen - 1) junkStart(i + rs);   // R9: start held during run
        else startReq = 1'b0;
        @(negedge clk);
      end
      chk(elen == 1 ? "R6 done after single" : "R8 done", seqDone, 1);
      chk("R8 valid low at done", idxValid, 0);
      chk("R9 no restart", unpred, 0);
      @(negedge clk);
      chk("R8 done one cycle", seqDone, 0);
      chk("R9 idle after done", idxValid, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 valid in reset", idxValid, 0);
    chk("R10 done in reset", seqDone, 0);
    chk("R10 unpred in reset", unpred, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 valid after reset", idxValid, 0);
    chk("R10 unpred after reset", unpred, 0);
    for (int dbl = 0; dbl < 2; dbl++)
      for (int lf = 0; lf < 8; lf++)
        for (int ss = 0; ss < 2; ss++)
          for (int rs = 0; rs < 8; rs++)
            runCase(dbl, lf, 1, ss, rs);
    for (int k = 0; k < 8; k++) runCase(k % 2, k / 2, 0, k % 2, k);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule